// File: doc/BRIEF.md
# Receive Bit FIFO with Selectable Start Condition

This block buffers demodulated receive bits for a packet radio until a host drains them over a slow serial read port. Bits arrive one per strobe of the recovered bit clock, and the strobe is a single-cycle pulse in the system clock domain. Nothing is stored until the block is armed and a chosen start condition is seen. The condition can be the data-valid indicator, a 16-bit sync word, both of these at once, or no condition at all. Once storage begins it continues until the host clears the fill enable. Clearing and then setting the fill enable is also how the block is rearmed to hunt for the next packet.

The number of stored bits is compared with a programmable level. When the count reaches that level, an active-high interrupt and its active-low copy are raised. A level of one turns the interrupt into a not-empty flag, so the host can drain the FIFO until the interrupt drops. A bit that arrives while the FIFO is full is dropped and sets a sticky overflow flag.

Top module: `rxfifo_sync_start`

## Requirements
- R1: After reset, fifo_irq is 0, nirq is 1, overflow is 0 and rd_data is 0.
- R2: With start_sel = 01, a 0x2DD4 match starts storage. The match is taken over the last 16 strobed bits, with the earliest of them as bit 15. Bits up to and including the final sync bit are not stored, and storage begins with the next strobed bit.
- R3: With start_sel = 00, storage is armed by the first strobe that has data_valid = 1. That bit and all earlier bits are not stored.
- R4: With start_sel = 10, a sync match (as in R2) starts storage only on a strobe that has data_valid = 1. A match seen with data_valid = 0 has no effect.
- R5: With start_sel = 11, the first strobe after arming starts storage, and its own bit is not stored.
- R6: Once storage has started, it continues on every strobe while fill_en and fifo_en stay 1, even if the start condition drops.
- R7: Bits are read oldest first. rd_data shows the popped bit in the cycle after rd_en. A read from an empty FIFO gives rd_data = 0 and leaves the contents unchanged.
- R8: fifo_irq is 1 exactly when the stored count is at least irq_level, with a level of 0 treated as 1. nirq is always the inverse of fifo_irq.
- R9: A strobed bit that arrives while storing with 16 bits held is dropped and sets overflow. overflow stays set until fill_en or fifo_en is cleared.
- R10: Clearing fill_en stops storage and keeps the stored bits. Setting fill_en again restarts the hunt, and the hunt needs a complete new start condition.
- R11: While fifo_en is 0, the FIFO is empty and no bit is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Demodulated receive bit |
| bit_stb | input | 1 | One-cycle strobe from the recovered bit clock |
| data_valid | input | 1 | Data-valid indicator from the demodulator |
| start_sel | input | 2 | Start condition: 00 valid, 01 sync, 10 both, 11 always |
| irq_level | input | 4 | Fill level that raises the interrupt |
| fill_en | input | 1 | Fill enable; toggle low then high to rearm |
| fifo_en | input | 1 | FIFO enable; low empties the FIFO |
| rd_en | input | 1 | Pop request from the serial read side |
| rd_data | output | 1 | Popped bit, valid the cycle after rd_en |
| fifo_irq | output | 1 | Level interrupt, active high |
| nirq | output | 1 | Level interrupt, active low |
| overflow | output | 1 | Sticky dropped-bit flag |

## Verification
The bench uses the default parameters: a depth of 16, a 4-bit level and the sync word 0x2DD4. With a depth of 16, every interrupt level from 0 to 15 can be swept against every fill count from 1 to 16. It also lets the full boundary and the dropped-bit case be reached within a few dozen strobes. The fixed 16-bit sync word is small enough to send whole in each of the sync-based start modes, together with near-miss cases: a match seen while the data-valid indicator is low, and a hunt after rearming.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
// Shared types for the receive FIFO.
// Assumes the start-select encoding is fixed at two bits.
package rxf_pkg;
    typedef enum logic [1:0] {
        START_VALID  = 2'b00,
        START_SYNC   = 2'b01,
        START_BOTH   = 2'b10,
        START_ALWAYS = 2'b11
    } start_sel_e;
endpackage

// File: rtl/rxf_sync_detect.sv
`timescale 1ns/1ps
// Sync word detector: shifts strobed bits in MSB first and flags a match
// of the last SYNC_W bits against SYNC_WORD on the strobe itself.
// Assumes SYNC_W >= 2. Cleared while the hunt is not armed.
module rxf_sync_detect #(
    parameter int              SYNC_W    = 16,
    parameter logic [SYNC_W-1:0] SYNC_WORD = 16'h2DD4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bit_stb,
    input  logic bit_in,
    output logic hit
);
    logic [SYNC_W-1:0] shreg;
    logic [SYNC_W-1:0] next_window;

    assign next_window = {shreg[SYNC_W-2:0], bit_in};

    // Shift register of recent bits, emptied when the hunt is disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            shreg <= '0;
        end else if (bit_stb) begin
            shreg <= next_window;
        end
    end

    // Match flag for the window completed by the current strobe.
    always_comb begin
        hit = bit_stb && (next_window == SYNC_WORD);
    end
endmodule

// File: rtl/rxf_start_ctrl.sv
`timescale 1ns/1ps
// Start controller: while armed, waits for the selected start condition
// on a strobe and then holds the filling state until disarmed.
// Assumes sync_hit is only high together with bit_stb.
module rxf_start_ctrl
    import rxf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       armed,
    input  logic       bit_stb,
    input  logic       data_valid,
    input  logic       sync_hit,
    input  logic [1:0] start_sel,
    output logic       filling
);
    logic cond;

    // Decode of the selected start condition for this strobe.
    always_comb begin
        unique case (start_sel_e'(start_sel))
            START_VALID:  cond = bit_stb && data_valid;
            START_SYNC:   cond = sync_hit;
            START_BOTH:   cond = sync_hit && data_valid;
            START_ALWAYS: cond = bit_stb;
            default:      cond = 1'b0;
        endcase
    end

    // Filling state: set by the condition, cleared only by disarming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filling <= 1'b0;
        end else if (!armed) begin
            filling <= 1'b0;
        end else if (cond) begin
            filling <= 1'b1;
        end
    end
endmodule

// File: rtl/rxf_bit_store.sv
`timescale 1ns/1ps
// Bit store: a DEPTH x 1 circular FIFO with an occupancy count,
// a registered read bit and a sticky flag for writes refused when full.
// Assumes DEPTH >= 2. flush empties it and takes priority over all.
module rxf_bit_store #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic             wr_bit,
    input  logic             rd_en,
    input  logic             ovf_clear,
    output logic             rd_data,
    output logic [CNT_W-1:0] count,
    output logic             overflow
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [DEPTH-1:0] cells;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_wr;
    logic             do_rd;

    // Accept a write only when not full, a read only when not empty.
    always_comb begin
        do_wr = wr_en && (count != FULL_CNT);
        do_rd = rd_en && (count != '0);
    end

    // One storage cell per slot, loaded when the write pointer selects it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cells[i] <= 1'b0;
            end else if (do_wr && !flush && (wr_ptr == PTR_W'(i))) begin
                cells[i] <= wr_bit;
            end
        end
    end

    // Write pointer, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
        end else if (do_wr) begin
            wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
        end
    end

    // Read pointer, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
        end else if (do_rd) begin
            rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Occupancy count, with simultaneous read and write cancelling.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            count <= '0;
        end else if (do_wr && !do_rd) begin
            count <= count + 1'b1;
        end else if (do_rd && !do_wr) begin
            count <= count - 1'b1;
        end
    end

    // Registered read bit; an empty read returns zero.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_data <= 1'b0;
        end else if (do_rd) begin
            rd_data <= cells[rd_ptr];
        end else if (rd_en) begin
            rd_data <= 1'b0;
        end
    end

    // Sticky flag for a write refused because the store was full.
    always_ff @(posedge clk) begin
        if (!rst_n || ovf_clear) begin
            overflow <= 1'b0;
        end else if (wr_en && (count == FULL_CNT)) begin
            overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/rxfifo_sync_start.sv
`timescale 1ns/1ps
// Receive bit FIFO with selectable start condition. Strobed bits are
// stored once the armed start condition is met; the stored count is
// compared with a level to drive the interrupt pair.
// Assumes bit_stb is a single-cycle pulse in the clk domain and that
// LVL_W bits fit within the count width.
module rxfifo_sync_start #(
    parameter int                DEPTH     = 16,
    parameter int                LVL_W     = 4,
    parameter int                SYNC_W    = 16,
    parameter logic [SYNC_W-1:0] SYNC_WORD = 16'h2DD4,
    localparam int               CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             bit_stb,
    input  logic             data_valid,
    input  logic [1:0]       start_sel,
    input  logic [LVL_W-1:0] irq_level,
    input  logic             fill_en,
    input  logic             fifo_en,
    input  logic             rd_en,
    output logic             rd_data,
    output logic             fifo_irq,
    output logic             nirq,
    output logic             overflow
);
    logic             armed;
    logic             sync_hit;
    logic             filling;
    logic [CNT_W-1:0] fill_count;
    logic [CNT_W-1:0] eff_level;

    // Hunt is armed only with both enables set.
    always_comb begin
        armed = fill_en && fifo_en;
    end

    rxf_sync_detect #(
        .SYNC_W   (SYNC_W),
        .SYNC_WORD(SYNC_WORD)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (!armed),
        .bit_stb(bit_stb),
        .bit_in (bit_in),
        .hit    (sync_hit)
    );

    rxf_start_ctrl i_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed     (armed),
        .bit_stb   (bit_stb),
        .data_valid(data_valid),
        .sync_hit  (sync_hit),
        .start_sel (start_sel),
        .filling   (filling)
    );

    rxf_bit_store #(
        .DEPTH(DEPTH)
    ) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (!fifo_en),
        .wr_en    (filling && bit_stb),
        .wr_bit   (bit_in),
        .rd_en    (rd_en),
        .ovf_clear(!armed),
        .rd_data  (rd_data),
        .count    (fill_count),
        .overflow (overflow)
    );

    // Level compare; a programmed zero behaves as one.
    always_comb begin
        eff_level = (irq_level == '0) ? CNT_W'(1) : CNT_W'(irq_level);
        fifo_irq  = (fill_count >= eff_level);
        nirq      = !fifo_irq;
    end
endmodule

// File: rtl/rxf_checker.sv
`timescale 1ns/1ps
// Property checker for rxfifo_sync_start, attached by bind below.
// Observes the top ports and the filling state and count between submodules.
module rxf_checker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             fill_en,
    input logic             rd_en,
    input logic             filling,
    input logic [CNT_W-1:0] fill_count,
    input logic             overflow,
    input logic             fifo_irq,
    input logic             rd_data
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    // R2: nothing is added to the store before the start condition is met.
    p_no_store_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !filling |=> fill_count <= $past(fill_count));

    // R6: filling persists while both enables stay set.
    p_fill_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        filling && fill_en && fifo_en |=> filling);

    // R7: a read from an empty store returns zero.
    p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && fifo_en && (fill_count == '0) |=> rd_data == 1'b0);

    // R8: the interrupt never stands on an empty store.
    p_irq_needs_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_irq |-> fill_count != '0);

    // R9: overflow only rises out of a full store.
    p_ovf_from_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(fill_count) == FULL_CNT);

    // R9: overflow is sticky while armed.
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && fill_en && fifo_en |=> overflow);

    // R11: disabling the FIFO empties it.
    p_disabled_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |=> fill_count == '0);
endmodule

bind rxfifo_sync_start rxf_checker #(
    .DEPTH(DEPTH),
    .CNT_W(CNT_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_en   (fifo_en),
    .fill_en   (fill_en),
    .rd_en     (rd_en),
    .filling   (filling),
    .fill_count(fill_count),
    .overflow  (overflow),
    .fifo_irq  (fifo_irq),
    .rd_data   (rd_data)
);

// File: tb/test_rxfifo_sync_start.sv
`timescale 1ns/1ps
// Self-checking bench for rxfifo_sync_start with default parameters.
module test_rxfifo_sync_start;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_stb = 1'b0;
    logic       data_valid = 1'b0;
    logic [1:0] start_sel = 2'b00;
    logic [3:0] irq_level = 4'd1;
    logic       fill_en = 1'b0;
    logic       fifo_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_data;
    logic       fifo_irq;
    logic       nirq;
    logic       overflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit exp_q[$];

    always #2 clk = ~clk;

    rxfifo_sync_start i_rxfifo_sync_start (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_stb(bit_stb),
        .data_valid(data_valid), .start_sel(start_sel), .irq_level(irq_level),
        .fill_en(fill_en), .fifo_en(fifo_en), .rd_en(rd_en), .rd_data(rd_data),
        .fifo_irq(fifo_irq), .nirq(nirq), .overflow(overflow)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send_bit(input bit b, input bit v);
        @(negedge clk);
        bit_in = b; data_valid = v; bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] val, input int n, input bit v, input bit store);
        for (int i = n - 1; i >= 0; i--) begin
            send_bit(val[i], v);
            if (store) exp_q.push_back(val[i]);
        end
    endtask

    task automatic pop(output bit b);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        b = rd_data;
    endtask

    task automatic arm(input logic [1:0] sel, input logic [3:0] lvl);
        @(negedge clk);
        fifo_en = 1'b0; fill_en = 1'b0;
        @(negedge clk);
        start_sel = sel; irq_level = lvl; fifo_en = 1'b1; fill_en = 1'b1;
    endtask

    task automatic drain(input string tag);
        bit b;
        while (exp_q.size() > 0) begin
            pop(b);
            chk(tag, b, exp_q.pop_front());
        end
        chk({tag, " empty after drain"}, fifo_irq, 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit b;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 irq", fifo_irq, 0);
        chk("R1 nirq", nirq, 1);
        chk("R1 overflow", overflow, 0);
        chk("R1 rd_data", rd_data, 0);
        rst_n = 1'b1;

        // R2 sync start: preamble and sync not stored
        arm(2'b01, 4'd1);
        send_bits(32'hAAAA, 16, 1'b0, 1'b0);
        chk("R2 preamble not stored", nirq, 1);
        send_bits(32'h2DD4, 16, 1'b0, 1'b0);
        chk("R2 sync bits not stored", nirq, 1);
        send_bits(32'hA5D, 12, 1'b0, 1'b1);
        chk("R2 payload stored", nirq, 0);
        drain("R2/R7 order");
        // R7 empty read gives zero (last drained bit was 1)
        pop(b);
        chk("R7 empty read data", b, 0);
        chk("R7 empty read irq", fifo_irq, 0);

        // R3 valid start, R6 continues when valid drops
        arm(2'b00, 4'd1);
        send_bits(32'hFF, 8, 1'b0, 1'b0);
        chk("R3 invalid bits ignored", nirq, 1);
        send_bit(1'b1, 1'b1);
        chk("R3 trigger bit not stored", nirq, 1);
        send_bits(32'h2B3, 10, 1'b0, 1'b1);
        chk("R6 storing after valid drops", fifo_irq, 1);
        drain("R6 content");

        // R4 both: sync with valid low has no effect
        arm(2'b10, 4'd1);
        send_bits(32'h2DD4, 16, 1'b0, 1'b0);
        send_bits(32'h00, 8, 1'b1, 1'b0);
        chk("R4 sync without valid ignored", nirq, 1);
        send_bits(32'h2DD4, 16, 1'b1, 1'b0);
        chk("R4 sync bits not stored", nirq, 1);
        send_bits(32'h2D, 6, 1'b1, 1'b1);
        drain("R4 content");

        // R5 always
        arm(2'b11, 4'd1);
        send_bit(1'b1, 1'b0);
        chk("R5 first bit not stored", nirq, 1);
        send_bits(32'h17, 5, 1'b0, 1'b1);
        drain("R5 content");

        // R8 sweep of every level against every count
        for (int lvl = 0; lvl < 16; lvl++) begin
            arm(2'b11, lvl[3:0]);
            send_bit(1'b0, 1'b0);
            for (int k = 1; k <= 16; k++) begin
                int eff;
                send_bit(k[0], 1'b0);
                eff = (lvl == 0) ? 1 : lvl;
                chk($sformatf("R8 irq lvl %0d cnt %0d", lvl, k), fifo_irq, (k >= eff) ? 1 : 0);
                chk($sformatf("R8 nirq lvl %0d cnt %0d", lvl, k), nirq, (k >= eff) ? 0 : 1);
            end
        end

        // R9 overflow: FIFO holds 1,0,1,0,... from the last sweep run
        chk("R9 no overflow at full", overflow, 0);
        send_bit(1'b0, 1'b0);
        send_bit(1'b0, 1'b0);
        chk("R9 overflow set", overflow, 1);
        for (int k = 1; k <= 16; k++) exp_q.push_back(k[0]);
        drain("R9 oldest kept");
        chk("R9 overflow sticky", overflow, 1);
        @(negedge clk); fill_en = 1'b0;
        @(negedge clk);
        chk("R9 overflow cleared by fill_en", overflow, 0);

        // R10 rearm keeps data and needs a new sync
        arm(2'b01, 4'd1);
        send_bits(32'h2DD4, 16, 1'b0, 1'b0);
        send_bits(32'hF, 4, 1'b0, 1'b1);
        @(negedge clk); fill_en = 1'b0;
        @(negedge clk); fill_en = 1'b1;
        send_bits(32'hFF, 8, 1'b0, 1'b0);
        chk("R10 data kept", fifo_irq, 1);
        drain("R10 only first packet");
        send_bits(32'h2DD4, 16, 1'b0, 1'b0);
        chk("R10 new sync not stored", nirq, 1);
        send_bits(32'h5, 3, 1'b0, 1'b1);
        drain("R10 second packet");

        // R11 fifo_en low empties and blocks storage
        arm(2'b11, 4'd1);
        send_bit(1'b1, 1'b0);
        send_bits(32'h7, 3, 1'b0, 1'b0);
        chk("R11 stored before disable", fifo_irq, 1);
        @(negedge clk); fifo_en = 1'b0;
        @(negedge clk);
        chk("R11 emptied", fifo_irq, 0);
        send_bits(32'h7, 3, 1'b0, 1'b0);
        chk("R11 no storage while disabled", fifo_irq, 0);
        pop(b);
        chk("R11 read while disabled", b, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule